// File: doc/BRIEF.md
# Branch Trace Record Store Engine

The engine accepts control-flow events and information events and turns each one into a fixed-size trace record. Records go into a circular buffer that sits in a word-addressed on-block memory. A record is three machine words long, so it is 12 bytes at a 32-bit word and 24 bytes at a 64-bit word. Software sets up four byte-address pointers: the buffer start, the current write position, the wrap limit and the interrupt threshold. The wrap limit is the first byte past the buffer. After each record is stored the write position moves forward by one record. It returns to the buffer start once it reaches or passes the wrap limit.

A branch record holds a source and a destination address. An information record is marked in-band: its source word is all ones, it carries a one-byte type code and it carries one data word. A sticky interrupt flag is raised when the write position reaches the threshold, and software clears it with a write-one-to-clear strobe. A clear command fills the whole buffer with zeros and rewinds the write position. A read command fetches the record at a given slot number and decodes it into branch or information form.

Top module: `trs_store`

## Requirements
- R1: A branch event (`ev_kind` = 1) stores a record whose word 0 is the source, word 1 is the destination and word 2 is zero. Reading that slot back returns `rd_info`=0 with the same source and destination.
- R2: An information event (`ev_kind` = 2) stores all ones in word 0, the type code in bits 7:0 of word 1 with the upper bits zero, and the data value in word 2. Reading it back returns `rd_info`=1 with that type and data, and zero source and destination.
- R3: A void event (`ev_kind` = 0) stores an all-zero record and still advances the write position. It reads back as a branch from 0 to 0.
- R4: After each stored record the write position becomes position + 3·word-bytes. If that value is at or beyond the wrap limit, the position becomes the buffer start instead.
- R5: `irq` is set when a stored record leaves the write position at or above the threshold. It stays set until `irq_clr` is pulsed. A threshold of wrap limit + 1 never sets it.
- R6: `clr_req` writes zero to every word from the buffer start up to the wrap limit, then sets the write position to the buffer start. Every slot then reads back as a branch from 0 to 0.
- R7: A slot whose word 0 is all ones reads back as information, even if it was written as a branch. Any other slot reads back as a branch.
- R8: A read of a slot number at or above the capacity returns `rd_done` together with `rd_err`=1 and zero fields.
- R9: An event is rejected, leaving the write position and buffer unchanged, when the capacity is zero or when `ev_kind` = 3. The rejection is signalled by a one-cycle `wr_rej` pulse in the cycle after the request.
- R10: `cap` equals floor((wrap limit − start)/record bytes), or 0 when the limit is not above the start. `slot` equals (position − start)/record bytes.
- R11: After reset all four pointers, `irq`, `busy`, `rd_done` and `wr_rej` are zero.
- R12: Pointer writes use `cfg_sel` 0 = buffer start, 1 = write position, 2 = wrap limit, 3 = threshold. They take effect only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pointer write strobe |
| cfg_sel | input | 2 | Pointer select (0 start, 1 position, 2 limit, 3 threshold) |
| cfg_wdata | input | ADDR_W | Pointer value, byte address |
| pos | output | ADDR_W | Current write position |
| cap | output | ADDR_W | Buffer capacity in records |
| slot | output | ADDR_W | Current write slot number |
| irq | output | 1 | Sticky threshold interrupt |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |
| ev_valid | input | 1 | Event request |
| ev_kind | input | 2 | 0 void, 1 branch, 2 information, 3 reserved |
| ev_src | input | WORD_W | Branch source address |
| ev_dst | input | WORD_W | Branch destination address |
| ev_type | input | 8 | Information type code |
| ev_data | input | WORD_W | Information data word |
| wr_rej | output | 1 | Event rejected pulse |
| clr_req | input | 1 | Buffer clear request |
| rd_req | input | 1 | Slot read request |
| rd_slot | input | ADDR_W | Slot number to read |
| rd_done | output | 1 | Read result valid pulse |
| rd_err | output | 1 | Slot out of range |
| rd_info | output | 1 | Decoded record is information |
| rd_type | output | 8 | Decoded type code |
| rd_src | output | WORD_W | Decoded source address |
| rd_dst | output | WORD_W | Decoded destination address |
| rd_data | output | WORD_W | Decoded data word |
| busy | output | 1 | Engine is in a multi-cycle operation |

## Verification
The bench builds the engine with a 32-bit word and a 10-bit byte address, which gives 12-byte records and a 256-word memory. One buffer holds exactly five records. A second buffer's wrap limit is 8 bytes past a four-record boundary, so the partial-record wrap is exercised. With buffers this small, the random mix of events wraps many times and crosses the threshold often. It also tests reads at the capacity edge and branches whose source is all ones.

// File: rtl/trs_pkg.sv
package trs_pkg;

  typedef enum logic [1:0] {
    EVK_VOID   = 2'd0,
    EVK_BRANCH = 2'd1,
    EVK_INFO   = 2'd2,
    EVK_RSVD   = 2'd3
  } evk_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_CLR,
    ST_RD
  } st_e;

  localparam int unsigned REC_WORDS = 3;

endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int W  = 32,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [MW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << MW;

  logic [W-1:0] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/trs_ptr.sv
module trs_ptr #(
  parameter int ADDR_W    = 10,
  parameter int REC_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              adv,
  input  logic              rewind,
  input  logic              irq_clr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] endp,
  output logic              irq,
  output logic [ADDR_W-1:0] cap,
  output logic [ADDR_W-1:0] slot
);
  logic [ADDR_W-1:0] thr;
  logic [ADDR_W:0]   step;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] used;

  assign step = {1'b0, idx} + (ADDR_W+1)'(REC_BYTES);
  assign nxt  = (step >= {1'b0, endp}) ? base : step[ADDR_W-1:0];
  assign span = endp - base;
  assign used = idx - base;
  assign cap  = (endp > base) ? span / ADDR_W'(REC_BYTES) : '0;
  assign slot = (idx >= base) ? used / ADDR_W'(REC_BYTES) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      idx  <= '0;
      endp <= '0;
      thr  <= '0;
      irq  <= 1'b0;
    end else begin
      if (cfg_we) begin
        unique case (cfg_sel)
          2'd0:    base <= cfg_wdata;
          2'd1:    idx  <= cfg_wdata;
          2'd2:    endp <= cfg_wdata;
          default: thr  <= cfg_wdata;
        endcase
      end else if (adv) begin
        idx <= nxt;
      end else if (rewind) begin
        idx <= base;
      end
      if (adv && (nxt >= thr)) irq <= 1'b1;
      else if (irq_clr)        irq <= 1'b0;
    end
  end

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && !cfg_we |=> (idx == $past(base)) || (idx == $past(idx) + ADDR_W'(REC_BYTES)));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clr |=> irq);

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(adv));

  // R6
  rewind_chk: assert property (@(posedge clk) disable iff (rst)
    rewind && !cfg_we && !adv |=> idx == $past(base));
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [WORD_W-1:0] ev_src,
  input  logic [WORD_W-1:0] ev_dst,
  input  logic [7:0]        ev_type,
  input  logic [WORD_W-1:0] ev_data,
  input  logic              clr_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_slot,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] idx,
  input  logic [ADDR_W-1:0] endp,
  input  logic [ADDR_W-1:0] cap,
  output logic              mem_we,
  output logic [ADDR_W-$clog2(WORD_W/8)-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              adv,
  output logic              rewind,
  output logic              wr_rej,
  output logic              rd_done,
  output logic              rd_err,
  output logic              rd_info,
  output logic [7:0]        rd_type,
  output logic [WORD_W-1:0] rd_src,
  output logic [WORD_W-1:0] rd_dst,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy
);
  localparam int WB   = WORD_W / 8;
  localparam int WLOG = $clog2(WB);
  localparam int MW   = ADDR_W - WLOG;

  st_e               st;
  logic [1:0]        cnt;
  logic [MW-1:0]     wa;
  logic [WORD_W-1:0] lw0, lw1, lw2;
  logic [WORD_W-1:0] rw0, rw1;
  logic [WORD_W-1:0] rec0, rec1, rec2;

  logic [MW-1:0]     base_w, idx_w, end_w, end_last;
  logic [ADDR_W+1:0] slot_x3;
  logic [MW-1:0]     rd_w0;
  logic              rej, clr_none, rw0_ones;
  logic              unused_bits;

  assign base_w   = base[ADDR_W-1:WLOG];
  assign idx_w    = idx[ADDR_W-1:WLOG];
  assign end_w    = endp[ADDR_W-1:WLOG];
  assign end_last = end_w - MW'(1);
  assign slot_x3  = {2'b00, rd_slot} * (ADDR_W+2)'(REC_WORDS);
  assign rd_w0    = base_w + slot_x3[MW-1:0];
  assign rej      = (evk_e'(ev_kind) == EVK_RSVD) || (cap == '0);
  assign clr_none = (end_w <= base_w);
  assign rw0_ones = (rw0 == '1);
  assign unused_bits = ^{base[WLOG-1:0], idx[WLOG-1:0], endp[WLOG-1:0], slot_x3[ADDR_W+1:MW]};

  always_comb begin
    rec0 = '0;
    rec1 = '0;
    rec2 = '0;
    unique case (evk_e'(ev_kind))
      EVK_BRANCH: begin
        rec0 = ev_src;
        rec1 = ev_dst;
      end
      EVK_INFO: begin
        rec0 = '1;
        rec1 = {{(WORD_W-8){1'b0}}, ev_type};
        rec2 = ev_data;
      end
      default: ;
    endcase
  end

  always_comb begin
    mem_we    = (st == ST_WR) || (st == ST_CLR);
    mem_addr  = wa;
    mem_wdata = '0;
    if (st == ST_WR) begin
      unique case (cnt)
        2'd0:    mem_wdata = lw0;
        2'd1:    mem_wdata = lw1;
        default: mem_wdata = lw2;
      endcase
    end
    adv    = (st == ST_WR) && (cnt == 2'd2);
    rewind = ((st == ST_CLR) && (wa == end_last)) ||
             ((st == ST_IDLE) && clr_req && clr_none);
    busy   = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      wa      <= '0;
      lw0     <= '0;
      lw1     <= '0;
      lw2     <= '0;
      rw0     <= '0;
      rw1     <= '0;
      wr_rej  <= 1'b0;
      rd_done <= 1'b0;
      rd_err  <= 1'b0;
      rd_info <= 1'b0;
      rd_type <= '0;
      rd_src  <= '0;
      rd_dst  <= '0;
      rd_data <= '0;
    end else begin
      wr_rej  <= 1'b0;
      rd_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (clr_req) begin
            if (!clr_none) begin
              st <= ST_CLR;
              wa <= base_w;
            end
          end else if (ev_valid) begin
            if (rej) begin
              wr_rej <= 1'b1;
            end else begin
              st  <= ST_WR;
              wa  <= idx_w;
              lw0 <= rec0;
              lw1 <= rec1;
              lw2 <= rec2;
            end
          end else if (rd_req) begin
            if (rd_slot >= cap) begin
              rd_done <= 1'b1;
              rd_err  <= 1'b1;
              rd_info <= 1'b0;
              rd_type <= '0;
              rd_src  <= '0;
              rd_dst  <= '0;
              rd_data <= '0;
            end else begin
              st <= ST_RD;
              wa <= rd_w0;
            end
          end
        end
        ST_WR: begin
          wa  <= wa + MW'(1);
          cnt <= cnt + 2'd1;
          if (cnt == 2'd2) st <= ST_IDLE;
        end
        ST_CLR: begin
          wa <= wa + MW'(1);
          if (wa == end_last) st <= ST_IDLE;
        end
        ST_RD: begin
          wa  <= wa + MW'(1);
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) rw0 <= mem_rdata;
          if (cnt == 2'd2) rw1 <= mem_rdata;
          if (cnt == 2'd3) begin
            st      <= ST_IDLE;
            rd_done <= 1'b1;
            rd_err  <= 1'b0;
            rd_info <= rw0_ones;
            rd_type <= rw0_ones ? rw1[7:0] : 8'h00;
            rd_src  <= rw0_ones ? '0 : rw0;
            rd_dst  <= rw0_ones ? '0 : rw1;
            rd_data <= rw0_ones ? mem_rdata : '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  rej_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_rej |-> $past(ev_valid) && !busy);

  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_err) |-> rd_done);

  // R7
  info_fields_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done && rd_info |-> (rd_src == '0) && (rd_dst == '0));

  // R1
  adv_last_word_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> mem_we && $past(mem_we));
endmodule

// File: rtl/trs_store.sv
module trs_store
  import trs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] pos,
  output logic [ADDR_W-1:0] cap,
  output logic [ADDR_W-1:0] slot,
  output logic              irq,
  input  logic              irq_clr,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [WORD_W-1:0] ev_src,
  input  logic [WORD_W-1:0] ev_dst,
  input  logic [7:0]        ev_type,
  input  logic [WORD_W-1:0] ev_data,
  output logic              wr_rej,
  input  logic              clr_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_slot,
  output logic              rd_done,
  output logic              rd_err,
  output logic              rd_info,
  output logic [7:0]        rd_type,
  output logic [WORD_W-1:0] rd_src,
  output logic [WORD_W-1:0] rd_dst,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy
);
  localparam int WB        = WORD_W / 8;
  localparam int WLOG      = $clog2(WB);
  localparam int MW        = ADDR_W - WLOG;
  localparam int REC_BYTES = int'(REC_WORDS) * WB;

  logic [ADDR_W-1:0] base, endp;
  logic              adv, rewind, cfg_ok;
  logic              mem_we;
  logic [MW-1:0]     mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  assign cfg_ok = cfg_we && !busy;

  trs_ptr #(.ADDR_W(ADDR_W), .REC_BYTES(REC_BYTES)) u_ptr (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_ok), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .adv(adv), .rewind(rewind), .irq_clr(irq_clr),
    .base(base), .idx(pos), .endp(endp), .irq(irq),
    .cap(cap), .slot(slot)
  );

  trs_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_src(ev_src), .ev_dst(ev_dst),
    .ev_type(ev_type), .ev_data(ev_data),
    .clr_req(clr_req), .rd_req(rd_req), .rd_slot(rd_slot),
    .base(base), .idx(pos), .endp(endp), .cap(cap),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .adv(adv), .rewind(rewind), .wr_rej(wr_rej),
    .rd_done(rd_done), .rd_err(rd_err), .rd_info(rd_info), .rd_type(rd_type),
    .rd_src(rd_src), .rd_dst(rd_dst), .rd_data(rd_data), .busy(busy)
  );

  trs_ram #(.W(WORD_W), .MW(MW)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  // R12
  cfg_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cfg_we && !adv && !rewind |=> $stable(pos) && $stable(cap));
endmodule

// File: tb/trs_store_test.sv
module trs_store_test;
  localparam int WW = 32;
  localparam int AW = 10;
  localparam int RB = 12;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we; logic [1:0] cfg_sel; logic [AW-1:0] cfg_wdata;
  logic [AW-1:0] pos, cap, slot;
  logic irq, irq_clr;
  logic ev_valid; logic [1:0] ev_kind;
  logic [WW-1:0] ev_src, ev_dst, ev_data; logic [7:0] ev_type;
  logic wr_rej, clr_req, rd_req; logic [AW-1:0] rd_slot;
  logic rd_done, rd_err, rd_info; logic [7:0] rd_type;
  logic [WW-1:0] rd_src, rd_dst, rd_data;
  logic busy;

  trs_store #(.WORD_W(WW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pos(pos), .cap(cap), .slot(slot), .irq(irq), .irq_clr(irq_clr),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_src(ev_src), .ev_dst(ev_dst),
    .ev_type(ev_type), .ev_data(ev_data), .wr_rej(wr_rej), .clr_req(clr_req),
    .rd_req(rd_req), .rd_slot(rd_slot), .rd_done(rd_done), .rd_err(rd_err),
    .rd_info(rd_info), .rd_type(rd_type), .rd_src(rd_src), .rd_dst(rd_dst),
    .rd_data(rd_data), .busy(busy)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mm [0:255];
  int unsigned mbase = 0, midx = 0, mend = 0, mthr = 0;
  logic mirq = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int unsigned m_cap();
    return (mend > mbase) ? (mend - mbase) / RB : 0;
  endfunction

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin @(negedge clk); g++; end
    if (g >= 2000) check("watchdog busy", 1, 0);
  endtask

  task automatic check_ptrs(input string req);
    check({req, " pos"}, 64'(pos), 64'(midx));
    check({req, " irq"}, 64'(irq), 64'(mirq));
    check({req, " slot R10"}, 64'(slot), 64'((midx >= mbase) ? (midx - mbase) / RB : 0));
  endtask

  task automatic set_ptr(input int sel, input int unsigned v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = AW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: mbase = v;
      1: midx = v;
      2: mend = v;
      default: mthr = v;
    endcase
  endtask

  task automatic post_ev(input int kind, input logic [31:0] s, input logic [31:0] d,
                         input logic [7:0] t, input logic [31:0] dat);
    logic rj;
    int unsigned w;
    int unsigned nx;
    rj = (kind == 3) || (m_cap() == 0);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 2'(kind); ev_src = s; ev_dst = d; ev_type = t; ev_data = dat;
    @(negedge clk);
    ev_valid = 1'b0;
    check("R9 wr_rej", 64'(wr_rej), 64'(rj));
    wait_idle();
    if (!rj) begin
      w = midx / 4;
      case (kind)
        1: begin mm[w] = s; mm[w+1] = d; mm[w+2] = 0; end
        2: begin mm[w] = 32'hFFFF_FFFF; mm[w+1] = {24'h0, t}; mm[w+2] = dat; end
        default: begin mm[w] = 0; mm[w+1] = 0; mm[w+2] = 0; end
      endcase
      nx = midx + RB;
      if (nx >= mend) nx = mbase;
      midx = nx;
      if (nx >= mthr) mirq = 1'b1;
    end
    check_ptrs("R4/R5");
  endtask

  task automatic read_slot(input int unsigned sl, input string req);
    int g = 0;
    logic err_e, inf_e;
    logic [31:0] w0, w1, w2;
    err_e = (sl >= m_cap());
    w0 = 0; w1 = 0; w2 = 0;
    if (!err_e) begin
      w0 = mm[mbase/4 + sl*3]; w1 = mm[mbase/4 + sl*3 + 1]; w2 = mm[mbase/4 + sl*3 + 2];
    end
    inf_e = !err_e && (w0 == 32'hFFFF_FFFF);
    @(negedge clk);
    rd_req = 1'b1; rd_slot = AW'(sl);
    @(negedge clk);
    rd_req = 1'b0;
    while (!rd_done && g < 2000) begin @(negedge clk); g++; end
    check({req, " done"}, 64'(rd_done), 1);
    check({req, " R8 err"}, 64'(rd_err), 64'(err_e));
    check({req, " info"}, 64'(rd_info), 64'(inf_e));
    check({req, " src"}, 64'(rd_src), 64'((err_e || inf_e) ? 32'h0 : w0));
    check({req, " dst"}, 64'(rd_dst), 64'((err_e || inf_e) ? 32'h0 : w1));
    check({req, " type"}, 64'(rd_type), 64'(inf_e ? w1[7:0] : 8'h0));
    check({req, " data"}, 64'(rd_data), 64'(inf_e ? w2 : 32'h0));
    wait_idle();
  endtask

  task automatic clear_buf();
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    wait_idle();
    for (int unsigned a = mbase / 4; a < mend / 4; a++) mm[a] = 0;
    midx = mbase;
    check("R6 pos after clear", 64'(pos), 64'(midx));
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    mirq = 1'b0;
    check("R5 irq cleared", 64'(irq), 0);
  endtask

  initial begin
    #(8 * 150000);
    check("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) mm[i] = 0;
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; irq_clr = 0;
    ev_valid = 0; ev_kind = 0; ev_src = 0; ev_dst = 0; ev_type = 0; ev_data = 0;
    clr_req = 0; rd_req = 0; rd_slot = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 pos", 64'(pos), 0);
    check("R11 irq", 64'(irq), 0);
    check("R11 busy", 64'(busy), 0);
    check("R11 rd_done", 64'(rd_done), 0);
    check("R11 wr_rej", 64'(wr_rej), 0);
    check("R11 cap", 64'(cap), 0);

    // R9 zero capacity rejects
    post_ev(1, 32'h1234, 32'h5678, 8'h0, 32'h0);

    // first buffer: five records
    set_ptr(0, 'h40); set_ptr(2, 'h40 + 5*RB); set_ptr(1, 'h40); set_ptr(3, 'h40 + 5*RB + 1);
    check("R10 cap five", 64'(cap), 5);
    check("R12 pos written", 64'(pos), 'h40);
    clear_buf();
    for (int s = 0; s < 5; s++) read_slot(s, "R6 cleared slot");

    post_ev(1, 32'h1111_1111, 32'h2222_2222, 8'h00, 32'h0);   // R1
    post_ev(2, 32'h0, 32'h0, 8'hA5, 32'hDEAD_BEEF);            // R2
    post_ev(0, 32'h9, 32'h9, 8'h9, 32'h9);                     // R3
    post_ev(3, 32'h7, 32'h7, 8'h7, 32'h7);                     // R9 reserved kind
    post_ev(1, 32'hFFFF_FFFF, 32'h0000_0133, 8'h00, 32'h0);    // R7 in-band ambiguity
    read_slot(0, "R1 branch");
    read_slot(1, "R2 info");
    read_slot(2, "R3 void");
    read_slot(3, "R7 ones source");
    post_ev(1, 32'hA, 32'hB, 8'h0, 32'h0);                     // R4 fifth record wraps
    check("R4 wrapped to start", 64'(pos), 'h40);
    check("R5 far threshold silent", 64'(irq), 0);
    read_slot(5, "R8 at capacity");
    read_slot(1023, "R8 far slot");

    // R5 mid threshold
    set_ptr(3, 'h40 + 2*RB);
    post_ev(1, 32'h1, 32'h2, 8'h0, 32'h0);
    check("R5 below threshold", 64'(irq), 0);
    post_ev(2, 32'h0, 32'h0, 8'h3C, 32'h55);
    check("R5 reached threshold", 64'(irq), 1);
    pulse_irq_clr();

    // second buffer: end 8 bytes past a record boundary
    set_ptr(0, 'h100); set_ptr(2, 'h100 + 4*RB + 8); set_ptr(1, 'h100); set_ptr(3, 'h100 + 4*RB + 9);
    check("R10 cap rounded", 64'(cap), 4);
    clear_buf();

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r < 10) begin
        int k;
        logic [31:0] s;
        k = ($urandom % 10 == 0) ? 0 : (($urandom % 12 == 0) ? 3 : 1 + $urandom % 2);
        s = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
        post_ev(k, s, $urandom, 8'($urandom), $urandom);
      end else if (r < 13) begin
        read_slot($urandom % 6, "R7 random read");
      end else if (r == 13) begin
        clear_buf();
      end else if (r == 14) begin
        pulse_irq_clr();
      end else begin
        set_ptr(3, 'h100 + ($urandom % 60));
      end
    end
    check_ptrs("R4 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule